// File: doc/BRIEF.md
# MDIO Background PHY Scanner with User-Access Arbitration

This block keeps a live picture of which PHYs on a management bus respond and which of them report link up, without any help from software. While its enable input is high it issues one read frame after another, stepping the PHY address from 0 up to 31 and then wrapping. Each frame reads the PHY basic status register. The acknowledge of the frame and one bit of the returned data are stored in two 32-bit bitmaps: a presence map and a link map.

The block does not serialise frames itself. It drives a frame request towards a shared frame engine and waits for that engine's completion pulse. Software-initiated register accesses use the same engine. Between two frames a waiting software access always goes first, so it waits at most for the one scan frame already in flight. When enable is dropped, the frame in flight completes and updates the maps. No further scan frame starts and the block reports idle. A full pass takes 32 frame times, so software should allow that long after enabling before it trusts the presence map.

Top module: `mdio_poller`

## Requirements
- R1: After reset, `alive_map` and `link_map` are all zero, `idle` is 1 and no frame is requested.
- R2: With enable high and no user request, scan frames go to PHY addresses 0, 1, ..., 31 and then 0 again. Every scan frame is a read (`fe_write`=0) of register 1 (`fe_reg`=1).
- R3: When a scan frame to address n completes, bit n of `alive_map` takes the value of `fe_ack`.
- R4: When a scan frame to address n completes, bit n of `link_map` takes bit 2 of `fe_rdata` if `fe_ack` is 1, and is cleared if `fe_ack` is 0. A link bit is therefore never set without its alive bit.
- R5: A scan frame to address n leaves every other bit of both maps unchanged.
- R6: When no frame is in flight and `user_req` is high, the user frame is launched before any scan frame. `fe_start` carries `user_write`, `user_phy`, `user_reg` and `user_wdata`, and `user_grant` pulses in the same cycle as `fe_start`.
- R7: A user request raised while a scan frame is in flight is launched with `fe_start` exactly two cycles after the `fe_done` cycle that ends that scan frame.
- R8: `user_done` pulses one cycle after the `fe_done` of a user frame and carries that frame's `fe_ack` and `fe_rdata`. A user frame changes neither map and does not advance the scan address.
- R9: With enable low, no scan frame starts. The frame in flight still completes, and once no frame is outstanding `idle` is 1.
- R10: The first scan frame after enable rises from the stopped state goes to address 0.
- R11: `fe_start` is a single-cycle pulse and is never raised while a frame is outstanding (between a `fe_start` and its `fe_done`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Scan enable |
| user_req | input | 1 | Software access request, held until `user_grant` |
| user_write | input | 1 | 1 = write frame, 0 = read frame |
| user_phy | input | 5 | PHY address of the software access |
| user_reg | input | 5 | Register address of the software access |
| user_wdata | input | 16 | Write data of the software access |
| user_grant | output | 1 | Pulse: software access launched |
| user_done | output | 1 | Pulse: software access finished |
| user_ack | output | 1 | PHY acknowledged the software access (valid with `user_done`) |
| user_rdata | output | 16 | Read data of the software access (valid with `user_done`) |
| fe_start | output | 1 | Frame request pulse to the frame engine |
| fe_write | output | 1 | Frame direction |
| fe_phy | output | 5 | Frame PHY address |
| fe_reg | output | 5 | Frame register address |
| fe_wdata | output | 16 | Frame write data |
| fe_done | input | 1 | Frame engine completion pulse |
| fe_ack | input | 1 | PHY acknowledged the completed frame |
| fe_rdata | input | 16 | Read data of the completed frame |
| alive_map | output | 32 | Per-address presence bitmap |
| link_map | output | 32 | Per-address link-status bitmap |
| idle | output | 1 | No frame outstanding |

## Verification
The scanner is run against two different presence and link patterns. Each pattern mixes addresses that ack with link up, ack with link down, and stay silent while reporting the link bit. This separates a correct per-bit update from one that ignores the acknowledge or writes the wrong position. A stop/restart sequence lets exactly one scan frame complete against an inverted pattern. It shows that only bit 0 moves and that a restart begins at address 0. A read request is injected just after a scan frame starts, and a write is issued with the scanner stopped. These measure the two-cycle hand-over, the forwarded fields, the returned acknowledge and data, and confirm that a user frame neither touches the maps nor skips a scan address.

// File: rtl/mdio_poll_pkg.sv
`timescale 1ns/1ps
package mdio_poll_pkg;
  // Owner of the shared frame engine
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_SCAN = 2'd1,
    OWN_USER = 2'd2
  } owner_e;
endpackage

// File: rtl/mdio_poll_seq.sv
`timescale 1ns/1ps
// Scan address counter: cleared while stopped, stepped after each scan frame.
module mdio_poll_seq #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst || clr) addr <= '0;
    else if (adv)   addr <= addr + 1'b1;
  end
endmodule

// File: rtl/mdio_poll_arb.sv
`timescale 1ns/1ps
// Frame launcher: user access first, then the scan, one frame at a time.
module mdio_poll_arb
  import mdio_poll_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int REG_W      = 5,
  parameter int DATA_W     = 16,
  parameter int STATUS_REG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [ADDR_W-1:0] scan_addr,
  input  logic              user_req,
  input  logic              user_write,
  input  logic [ADDR_W-1:0] user_phy,
  input  logic [REG_W-1:0]  user_reg,
  input  logic [DATA_W-1:0] user_wdata,
  output logic              user_grant,
  output logic              user_done,
  output logic              user_ack,
  output logic [DATA_W-1:0] user_rdata,
  output logic              fe_start,
  output logic              fe_write,
  output logic [ADDR_W-1:0] fe_phy,
  output logic [REG_W-1:0]  fe_reg,
  output logic [DATA_W-1:0] fe_wdata,
  input  logic              fe_done,
  input  logic              fe_ack,
  input  logic [DATA_W-1:0] fe_rdata,
  output logic              scan_done,
  output logic              scan_busy,
  output logic              idle
);
  owner_e owner;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner      <= OWN_NONE;
      fe_start   <= 1'b0;
      fe_write   <= 1'b0;
      fe_phy     <= '0;
      fe_reg     <= '0;
      fe_wdata   <= '0;
      user_grant <= 1'b0;
      user_done  <= 1'b0;
      user_ack   <= 1'b0;
      user_rdata <= '0;
    end else begin
      fe_start   <= 1'b0;
      user_grant <= 1'b0;
      user_done  <= 1'b0;
      unique case (owner)
        OWN_NONE: begin
          if (user_req) begin
            fe_start   <= 1'b1;
            fe_write   <= user_write;
            fe_phy     <= user_phy;
            fe_reg     <= user_reg;
            fe_wdata   <= user_wdata;
            user_grant <= 1'b1;
            owner      <= OWN_USER;
          end else if (enable) begin
            fe_start <= 1'b1;
            fe_write <= 1'b0;
            fe_phy   <= scan_addr;
            fe_reg   <= REG_W'(STATUS_REG);
            fe_wdata <= '0;
            owner    <= OWN_SCAN;
          end
        end
        OWN_SCAN: if (fe_done) owner <= OWN_NONE;
        OWN_USER: begin
          if (fe_done) begin
            user_done  <= 1'b1;
            user_ack   <= fe_ack;
            user_rdata <= fe_rdata;
            owner      <= OWN_NONE;
          end
        end
        default: owner <= OWN_NONE;
      endcase
    end
  end

  assign scan_busy = (owner == OWN_SCAN);
  assign scan_done = scan_busy && fe_done;
  assign idle      = (owner == OWN_NONE);
endmodule

// File: rtl/mdio_poll_maps.sv
`timescale 1ns/1ps
// Presence and link bitmaps, one flop pair per address.
module mdio_poll_maps #(
  parameter int ADDR_W = 5,
  localparam int NPHY  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ack,
  input  logic              link_bit,
  output logic [NPHY-1:0]   alive_map,
  output logic [NPHY-1:0]   link_map
);
  for (genvar i = 0; i < NPHY; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        alive_map[i] <= 1'b0;
        link_map[i]  <= 1'b0;
      end else if (upd && addr == ADDR_W'(i)) begin
        alive_map[i] <= ack;
        link_map[i]  <= ack & link_bit;
      end
    end
  end
endmodule

// File: rtl/mdio_poller.sv
`timescale 1ns/1ps
module mdio_poller #(
  parameter int ADDR_W     = 5,
  parameter int REG_W      = 5,
  parameter int DATA_W     = 16,
  parameter int STATUS_REG = 1,
  parameter int LINK_BIT   = 2,
  localparam int NPHY      = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              user_req,
  input  logic              user_write,
  input  logic [ADDR_W-1:0] user_phy,
  input  logic [REG_W-1:0]  user_reg,
  input  logic [DATA_W-1:0] user_wdata,
  output logic              user_grant,
  output logic              user_done,
  output logic              user_ack,
  output logic [DATA_W-1:0] user_rdata,
  output logic              fe_start,
  output logic              fe_write,
  output logic [ADDR_W-1:0] fe_phy,
  output logic [REG_W-1:0]  fe_reg,
  output logic [DATA_W-1:0] fe_wdata,
  input  logic              fe_done,
  input  logic              fe_ack,
  input  logic [DATA_W-1:0] fe_rdata,
  output logic [NPHY-1:0]   alive_map,
  output logic [NPHY-1:0]   link_map,
  output logic              idle
);
  logic [ADDR_W-1:0] scan_addr;
  logic              scan_done;
  logic              scan_busy;

  mdio_poll_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .clr  (!enable && !scan_busy),
    .adv  (scan_done),
    .addr (scan_addr)
  );

  mdio_poll_arb #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W), .STATUS_REG(STATUS_REG)
  ) u_arb (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .scan_addr  (scan_addr),
    .user_req   (user_req),
    .user_write (user_write),
    .user_phy   (user_phy),
    .user_reg   (user_reg),
    .user_wdata (user_wdata),
    .user_grant (user_grant),
    .user_done  (user_done),
    .user_ack   (user_ack),
    .user_rdata (user_rdata),
    .fe_start   (fe_start),
    .fe_write   (fe_write),
    .fe_phy     (fe_phy),
    .fe_reg     (fe_reg),
    .fe_wdata   (fe_wdata),
    .fe_done    (fe_done),
    .fe_ack     (fe_ack),
    .fe_rdata   (fe_rdata),
    .scan_done  (scan_done),
    .scan_busy  (scan_busy),
    .idle       (idle)
  );

  // The scan frame's address is still held on fe_phy when it completes
  mdio_poll_maps #(.ADDR_W(ADDR_W)) u_maps (
    .clk       (clk),
    .rst       (rst),
    .upd       (scan_done),
    .addr      (fe_phy),
    .ack       (fe_ack),
    .link_bit  (fe_rdata[LINK_BIT]),
    .alive_map (alive_map),
    .link_map  (link_map)
  );
endmodule

// File: rtl/mdio_poller_chk.sv
`timescale 1ns/1ps
module mdio_poller_chk #(
  parameter int ADDR_W     = 5,
  parameter int REG_W      = 5,
  parameter int STATUS_REG = 1,
  localparam int NPHY      = 1 << ADDR_W
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             user_req,
  input logic             user_grant,
  input logic             user_done,
  input logic             fe_start,
  input logic             fe_write,
  input logic [REG_W-1:0] fe_reg,
  input logic             fe_done,
  input logic [NPHY-1:0]  alive_map,
  input logic [NPHY-1:0]  link_map,
  input logic             idle
);
  logic outstanding;
  always_ff @(posedge clk) begin
    if (rst)          outstanding <= 1'b0;
    else if (fe_start) outstanding <= 1'b1;
    else if (fe_done)  outstanding <= 1'b0;
  end

  p_start_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    fe_start |=> !fe_start);
  p_one_frame_r11: assert property (@(posedge clk) disable iff (rst)
    fe_start |-> !outstanding);
  p_grant_with_start_r6: assert property (@(posedge clk) disable iff (rst)
    user_grant |-> fe_start && $past(user_req));
  p_scan_is_status_read_r2: assert property (@(posedge clk) disable iff (rst)
    (fe_start && !user_grant) |-> (!fe_write && fe_reg == REG_W'(STATUS_REG)));
  p_scan_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
    (fe_start && !user_grant) |-> $past(enable));
  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (rst)
    (idle && !enable && !user_req) |=> !fe_start);
  p_user_done_after_engine_r8: assert property (@(posedge clk) disable iff (rst)
    user_done |-> $past(fe_done));
  p_user_keeps_maps_r8: assert property (@(posedge clk) disable iff (rst)
    user_done |-> ($stable(alive_map) && $stable(link_map)));
  p_link_needs_alive_r4: assert property (@(posedge clk) disable iff (rst)
    (link_map & ~alive_map) == '0);
endmodule

bind mdio_poller mdio_poller_chk #(
  .ADDR_W(ADDR_W), .REG_W(REG_W), .STATUS_REG(STATUS_REG)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .user_req   (user_req),
  .user_grant (user_grant),
  .user_done  (user_done),
  .fe_start   (fe_start),
  .fe_write   (fe_write),
  .fe_reg     (fe_reg),
  .fe_done    (fe_done),
  .alive_map  (alive_map),
  .link_map   (link_map),
  .idle       (idle)
);

// File: tb/sim_mdio_poller.sv
`timescale 1ns/1ps
module sim_mdio_poller;
  localparam int LAT = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        user_req = 1'b0;
  logic        user_write = 1'b0;
  logic [4:0]  user_phy = '0;
  logic [4:0]  user_reg = '0;
  logic [15:0] user_wdata = '0;
  logic        user_grant, user_done, user_ack;
  logic [15:0] user_rdata;
  logic        fe_start, fe_write;
  logic [4:0]  fe_phy, fe_reg;
  logic [15:0] fe_wdata;
  logic        fe_done = 1'b0;
  logic        fe_ack = 1'b0;
  logic [15:0] fe_rdata = '0;
  logic [31:0] alive_map, link_map;
  logic        idle;

  always #2.5 clk = ~clk;

  mdio_poller u0 (.*);

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // PHY population seen by the engine model
  logic [31:0] m_pres = '0;
  logic [31:0] m_link = '0;

  // Engine model log
  int         frame_cnt = 0;
  int         plog_n = 0;
  logic [4:0] plog [0:63];
  int         scan_bad = 0;
  int         done_cyc = 0;

  function automatic logic [15:0] phy_data(input logic [4:0] p, input logic [4:0] r);
    if (r == 5'd1) return 16'h7809 | ({15'b0, m_link[p]} << 2);
    return {p, r, 6'h2B};
  endfunction

  initial begin : engine
    logic [4:0] f_phy, f_reg;
    logic       f_wr;
    forever begin
      @(negedge clk);
      fe_done = 1'b0;
      if (fe_start) begin
        f_phy = fe_phy; f_reg = fe_reg; f_wr = fe_write;
        frame_cnt++;
        if (!user_grant) begin
          if (plog_n < 64) plog[plog_n] = f_phy;
          plog_n++;
          if (f_wr || f_reg != 5'd1) scan_bad++;
        end
        repeat (LAT) @(negedge clk);
        fe_done  = 1'b1;
        fe_ack   = m_pres[f_phy];
        fe_rdata = f_wr ? 16'h0 : phy_data(f_phy, f_reg);
        done_cyc = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  localparam logic [31:0] A_PRES = 32'hA5C3_0F71, A_LINK = 32'h3C3C_FFFF;
  localparam logic [31:0] B_PRES = 32'h5A3C_F28F, B_LINK = 32'hFFFF_0303;

  task automatic t_reset;
    settle(20);
    chk(alive_map == 0, "R1 alive after reset", alive_map, 0);
    chk(link_map == 0, "R1 link after reset", link_map, 0);
    chk(idle == 1'b1 && frame_cnt == 0, "R1 idle, no frame", {idle, 32'(frame_cnt)}, {1'b1, 32'd0});
  endtask

  task automatic t_full_pass;
    bit ord_ok = 1;
    m_pres = A_PRES; m_link = A_LINK;
    plog_n = 0;
    @(negedge clk); enable = 1'b1;
    wait (plog_n >= 33);
    settle(1);
    for (int i = 0; i < 33; i++) if (plog[i] != 5'(i % 32)) ord_ok = 0;
    chk(ord_ok, "R2 scan order 0..31 then 0", {59'd0, plog[32]}, 0);
    chk(plog[0] == 5'd0, "R10 first scan at address 0", plog[0], 0);
    chk(scan_bad == 0, "R2 scan frames are reads of reg 1", scan_bad, 0);
    chk(alive_map == A_PRES, "R3 alive pattern A", alive_map, A_PRES);
    chk(link_map == (A_PRES & A_LINK), "R4 link pattern A", link_map, A_PRES & A_LINK);
  endtask

  task automatic t_pattern_b;
    m_pres = B_PRES; m_link = B_LINK;
    plog_n = 0;
    wait (plog_n >= 34);
    settle(1);
    chk(alive_map == B_PRES, "R3 alive pattern B", alive_map, B_PRES);
    chk(link_map == (B_PRES & B_LINK), "R4 link pattern B", link_map, B_PRES & B_LINK);
  endtask

  task automatic t_stop_restart;
    int fc;
    plog_n = 0;
    wait (plog_n >= 5);
    enable = 1'b0;
    fc = frame_cnt;
    settle(3 * LAT + 20);
    chk(frame_cnt == fc, "R9 no scan after disable", frame_cnt, fc);
    chk(idle == 1'b1, "R9 idle after disable", idle, 1);
    chk(alive_map == B_PRES, "R9 in-flight frame result kept", alive_map, B_PRES);
    // one frame against an inverted population
    m_pres = ~B_PRES; m_link = ~B_LINK;
    plog_n = 0;
    enable = 1'b1;
    wait (plog_n >= 1);
    enable = 1'b0;
    settle(LAT + 10);
    chk(plog_n == 1 && plog[0] == 5'd0, "R10 restart at address 0", {27'd0, plog[0]}, 0);
    chk(alive_map == (B_PRES & ~32'h1), "R5 only bit 0 of alive moved", alive_map, B_PRES & ~32'h1);
    chk(link_map == ((B_PRES & B_LINK) & ~32'h1), "R5 only bit 0 of link moved",
        link_map, (B_PRES & B_LINK) & ~32'h1);
  endtask

  task automatic t_user_read;
    logic [4:0] a;
    int gcyc, dcyc;
    m_pres = B_PRES; m_link = B_LINK;
    plog_n = 0;
    enable = 1'b1;
    wait (plog_n >= 3);
    a = plog[2];
    user_req = 1'b1; user_write = 1'b0; user_phy = 5'd9; user_reg = 5'd3; user_wdata = 16'h1234;
    do begin @(negedge clk); #1; end while (!user_grant);
    gcyc = cyc; dcyc = done_cyc;
    user_req = 1'b0;
    chk(fe_start && fe_phy == 5'd9 && fe_reg == 5'd3 && !fe_write, "R6 user fields forwarded",
        {fe_start, fe_write, fe_phy, fe_reg}, {1'b1, 1'b0, 5'd9, 5'd3});
    chk(gcyc == dcyc + 2, "R7 hand-over two cycles after scan done", gcyc, dcyc + 2);
    do begin @(negedge clk); #1; end while (!user_done);
    chk(user_ack == B_PRES[9] && user_rdata == {5'd9, 5'd3, 6'h2B}, "R8 user read result",
        {user_ack, user_rdata}, {B_PRES[9], 5'd9, 5'd3, 6'h2B});
    chk(alive_map == B_PRES && link_map == (B_PRES & B_LINK), "R8 maps untouched by user frame",
        alive_map, B_PRES);
    wait (plog_n >= 4);
    #1;
    chk(plog[3] == a + 5'd1, "R8 scan resumes at next address", plog[3], a + 5'd1);
    enable = 1'b0;
    settle(2 * LAT + 10);
  endtask

  task automatic t_user_write_stopped;
    int fc;
    fc = frame_cnt;
    @(negedge clk);
    user_req = 1'b1; user_write = 1'b1; user_phy = 5'd4; user_reg = 5'd0; user_wdata = 16'hBEEF;
    do begin @(negedge clk); #1; end while (!user_grant);
    user_req = 1'b0;
    chk(fe_write && fe_phy == 5'd4 && fe_wdata == 16'hBEEF, "R6 user write fields",
        {fe_write, fe_phy, fe_wdata}, {1'b1, 5'd4, 16'hBEEF});
    do begin @(negedge clk); #1; end while (!user_done);
    chk(user_ack == B_PRES[4], "R8 write ack from absent PHY", user_ack, B_PRES[4]);
    settle(20);
    chk(frame_cnt == fc + 1 && idle, "R9 only the user frame ran while stopped",
        frame_cnt, fc + 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_full_pass();
    t_pattern_b();
    t_stop_restart();
    t_user_read();
    t_user_write_stopped();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule